// File: doc/BRIEF.md
# Single-Adder Accumulator Datapath Sequencer

This block is a 16-bit processor datapath in which one combinational adder carries every register transfer. Two operand multiplexers feed the adder. The first, the S side, picks the accumulator, the index register, the program counter, the memory data register, the address register or zero. The second, the U side, picks the operand register, the instruction register, the zero-extended address field of the instruction, or zero. The adder also takes a carry-in bit. Its sum is the only way to load the accumulator (A), the index register (X), the program counter (P) and the memory address register (M). A plain move is therefore an addition with a zero operand, and the counter increment is P plus zero plus carry-in.

A small sequencer runs micro-operations to fetch an instruction, step the program counter, and then either load A or X from memory, add a memory word into A, or do nothing. A synchronous read port links the block to memory. The address comes from M, and the returned word is captured into the memory data register W one cycle after the read strobe. The instruction word has the opcode in bits 15:8 and a direct address in bits 7:0. Opcode 0x01 loads A, 0x02 loads X, 0x03 adds to A, and every other opcode does nothing. A one-cycle retire pulse marks the moment the architectural outputs show a finished instruction.

Top module: `acc_datapath_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, A, X, P, the instruction register and the overflow flag read zero, and `mem_rd_en` and `retire_o` are low.
- R2: Each instruction is fetched from the address held in P. P then advances by exactly one per instruction and never changes by any other amount.
- R3: A memory word is captured one cycle after its read strobe, and `mem_rd_en` is never high in two consecutive cycles. An instruction with no operand takes 5 cycles. A load or an add takes 9 cycles: it issues a fetch read at P, then an operand read.
- R4: Opcode 0x01 (bits 15:8) writes the memory word at the effective address into A and leaves X and the overflow flag unchanged.
- R5: Opcode 0x02 writes the memory word at the effective address into X and leaves A and the overflow flag unchanged. X changes only on a retiring instruction.
- R6: Opcode 0x03 writes A plus the memory word, modulo 2^16, into A. Any carry out of bit 15 is dropped.
- R7: Every add sets the overflow flag to 1 when both operands have the same sign bit and the sum's sign bit differs, and clears it otherwise. No other instruction changes the flag.
- R8: Any opcode other than 0x01, 0x02 and 0x03 issues no operand read and leaves A, X and the overflow flag unchanged.
- R9: `retire_o` is a one-cycle pulse in the cycle after an instruction's final state. In that cycle the register outputs already hold that instruction's results, and `ir_o` shows its word.
- R10: The effective address is bits 7:0 of the instruction, zero-extended, so field 0xFF reads address 0x00FF whatever the opcode bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd_en | output | 1 | Read strobe to the synchronous memory |
| mem_addr | output | 16 | Read address, driven by the M register |
| mem_rdata | input | 16 | Read data, valid one cycle after the strobe |
| acc_o | output | 16 | Accumulator A |
| idx_o | output | 16 | Index register X |
| pc_o | output | 16 | Program counter P |
| ir_o | output | 16 | Instruction register |
| ovf_o | output | 1 | Signed overflow flag |
| retire_o | output | 1 | One-cycle pulse after an instruction completes |

## Verification
A wrong adder source selection or carry-in shows up at the next retire pulse as a wrong value on `acc_o`, `idx_o` or `pc_o`, so each fault is caught within one instruction of up to nine cycles. A sequencer that skips or repeats a state changes the gap between retire pulses or the order of read addresses, and this appears at the very next read strobe. A wrong effective address or a stale W register shows up as a mismatched read address or a wrong loaded value at that instruction's retire. A faulty overflow rule is seen on the add that crosses the sign boundary.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

   typedef enum logic [2:0] {
      SRC_S_ZERO = 3'd0,
      SRC_S_ACC  = 3'd1,
      SRC_S_IDX  = 3'd2,
      SRC_S_PC   = 3'd3,
      SRC_S_MDR  = 3'd4,
      SRC_S_MAR  = 3'd5
   } s_src_e;

   typedef enum logic [1:0] {
      SRC_U_ZERO = 2'd0,
      SRC_U_OPND = 2'd1,
      SRC_U_INST = 2'd2,
      SRC_U_EA   = 2'd3
   } u_src_e;

   typedef enum logic [3:0] {
      ST_F_ADDR = 4'd0,
      ST_F_READ = 4'd1,
      ST_F_WAIT = 4'd2,
      ST_F_INST = 4'd3,
      ST_DECODE = 4'd4,
      ST_O_READ = 4'd5,
      ST_O_WAIT = 4'd6,
      ST_O_OPND = 4'd7,
      ST_EXEC   = 4'd8
   } seq_st_e;

   typedef struct packed {
      s_src_e s_sel;
      u_src_e u_sel;
      logic   cin;
      logic   ld_mar;
      logic   ld_pc;
      logic   ld_acc;
      logic   ld_idx;
      logic   ld_mdr;
      logic   ld_inst;
      logic   ld_opnd;
      logic   ld_ovf;
      logic   rd_en;
      logic   last;
   } ctrl_t;

endpackage

// File: rtl/acc_dp_adder.sv
module acc_dp_adder #(
   parameter int unsigned WIDTH  = 16,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] s_in,
   input  logic [WIDTH-1:0] u_in,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = cin;
         for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign sum[b]     = s_in[b] ^ u_in[b] ^ carry[b];
            assign carry[b+1] = (s_in[b] & u_in[b]) | (carry[b] & (s_in[b] ^ u_in[b]));
         end
         assign ovf = carry[WIDTH] ^ carry[WIDTH-1];
      end else begin : g_flat
         assign sum = s_in + u_in + {{(WIDTH-1){1'b0}}, cin};
         assign ovf = (s_in[WIDTH-1] == u_in[WIDTH-1]) && (sum[WIDTH-1] != s_in[WIDTH-1]);
      end
   endgenerate

endmodule

// File: rtl/acc_dp_opmux.sv
module acc_dp_opmux
   import acc_dp_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned EA_W  = 8
) (
   input  s_src_e           s_sel,
   input  u_src_e           u_sel,
   input  logic [WIDTH-1:0] acc_q,
   input  logic [WIDTH-1:0] idx_q,
   input  logic [WIDTH-1:0] pc_q,
   input  logic [WIDTH-1:0] mdr_q,
   input  logic [WIDTH-1:0] mar_q,
   input  logic [WIDTH-1:0] opnd_q,
   input  logic [WIDTH-1:0] inst_q,
   output logic [WIDTH-1:0] s_bus,
   output logic [WIDTH-1:0] u_bus
);

   localparam int unsigned PAD_W = WIDTH - EA_W;

   logic [WIDTH-1:0] ea_ext;
   assign ea_ext = {{PAD_W{1'b0}}, inst_q[EA_W-1:0]};

   always_comb begin
      unique case (s_sel)
         SRC_S_ACC: s_bus = acc_q;
         SRC_S_IDX: s_bus = idx_q;
         SRC_S_PC:  s_bus = pc_q;
         SRC_S_MDR: s_bus = mdr_q;
         SRC_S_MAR: s_bus = mar_q;
         default:   s_bus = '0;
      endcase
   end

   always_comb begin
      unique case (u_sel)
         SRC_U_OPND: u_bus = opnd_q;
         SRC_U_INST: u_bus = inst_q;
         SRC_U_EA:   u_bus = ea_ext;
         default:    u_bus = '0;
      endcase
   end

endmodule

// File: rtl/acc_dp_seq.sv
module acc_dp_seq
   import acc_dp_pkg::*;
#(
   parameter int unsigned   OPC_W  = 8,
   parameter logic [OPC_W-1:0] OP_LDA = OPC_W'(1),
   parameter logic [OPC_W-1:0] OP_LDX = OPC_W'(2),
   parameter logic [OPC_W-1:0] OP_ADD = OPC_W'(3)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opcode,
   output ctrl_t            ctrl
);

   seq_st_e st_q, st_d;
   logic    is_mem;

   assign is_mem = (opcode == OP_LDA) || (opcode == OP_LDX) || (opcode == OP_ADD);

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_F_ADDR;
      else        st_q <= st_d;
   end

   always_comb begin
      ctrl = '0;
      ctrl.s_sel = SRC_S_ZERO;
      ctrl.u_sel = SRC_U_ZERO;
      st_d = st_q;
      unique case (st_q)
         ST_F_ADDR: begin
            ctrl.s_sel  = SRC_S_PC;
            ctrl.ld_mar = 1'b1;
            st_d        = ST_F_READ;
         end
         ST_F_READ: begin
            ctrl.rd_en = 1'b1;
            ctrl.s_sel = SRC_S_PC;
            ctrl.cin   = 1'b1;
            ctrl.ld_pc = 1'b1;
            st_d       = ST_F_WAIT;
         end
         ST_F_WAIT: begin
            ctrl.ld_mdr = 1'b1;
            st_d        = ST_F_INST;
         end
         ST_F_INST: begin
            ctrl.ld_inst = 1'b1;
            st_d         = ST_DECODE;
         end
         ST_DECODE: begin
            if (is_mem) begin
               ctrl.u_sel  = SRC_U_EA;
               ctrl.ld_mar = 1'b1;
               st_d        = ST_O_READ;
            end else begin
               ctrl.last = 1'b1;
               st_d      = ST_F_ADDR;
            end
         end
         ST_O_READ: begin
            ctrl.rd_en = 1'b1;
            st_d       = ST_O_WAIT;
         end
         ST_O_WAIT: begin
            ctrl.ld_mdr = 1'b1;
            st_d        = ST_O_OPND;
         end
         ST_O_OPND: begin
            ctrl.ld_opnd = 1'b1;
            st_d         = ST_EXEC;
         end
         ST_EXEC: begin
            ctrl.u_sel = SRC_U_OPND;
            ctrl.last  = 1'b1;
            if (opcode == OP_ADD) begin
               ctrl.s_sel  = SRC_S_ACC;
               ctrl.ld_acc = 1'b1;
               ctrl.ld_ovf = 1'b1;
            end else if (opcode == OP_LDX) begin
               ctrl.ld_idx = 1'b1;
            end else begin
               ctrl.ld_acc = 1'b1;
            end
            st_d = ST_F_ADDR;
         end
         default: st_d = ST_F_ADDR;
      endcase
   end

endmodule

// File: rtl/acc_datapath_seq.sv
module acc_datapath_seq
   import acc_dp_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OPC_W  = 8,
   parameter int unsigned EA_W   = 8,
   parameter bit          RIPPLE = 1'b0,
   parameter logic [OPC_W-1:0] OP_LDA = OPC_W'(1),
   parameter logic [OPC_W-1:0] OP_LDX = OPC_W'(2),
   parameter logic [OPC_W-1:0] OP_ADD = OPC_W'(3)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_rd_en,
   output logic [DATA_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] idx_o,
   output logic [DATA_W-1:0] pc_o,
   output logic [DATA_W-1:0] ir_o,
   output logic              ovf_o,
   output logic              retire_o
);

   localparam int unsigned OPC_LSB = DATA_W - OPC_W;

   generate
      if (OPC_W + EA_W > DATA_W) begin : g_bad_fields
         $error("opcode and address fields exceed the word width");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("word width too small");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [DATA_W-1:0] acc_q, idx_q, pc_q, mar_q, mdr_q, inst_q, opnd_q;
   logic              ovf_q, retire_q;
   logic [DATA_W-1:0] s_bus, u_bus, a_bus;
   logic              add_ovf;

   acc_dp_seq #(
      .OPC_W (OPC_W),
      .OP_LDA(OP_LDA),
      .OP_LDX(OP_LDX),
      .OP_ADD(OP_ADD)
   ) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .opcode(inst_q[DATA_W-1:OPC_LSB]),
      .ctrl  (ctrl)
   );

   acc_dp_opmux #(
      .WIDTH(DATA_W),
      .EA_W (EA_W)
   ) mux_i (
      .s_sel (ctrl.s_sel),
      .u_sel (ctrl.u_sel),
      .acc_q (acc_q),
      .idx_q (idx_q),
      .pc_q  (pc_q),
      .mdr_q (mdr_q),
      .mar_q (mar_q),
      .opnd_q(opnd_q),
      .inst_q(inst_q),
      .s_bus (s_bus),
      .u_bus (u_bus)
   );

   acc_dp_adder #(
      .WIDTH (DATA_W),
      .RIPPLE(RIPPLE)
   ) add_i (
      .s_in(s_bus),
      .u_in(u_bus),
      .cin (ctrl.cin),
      .sum (a_bus),
      .ovf (add_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q    <= '0;
         idx_q    <= '0;
         pc_q     <= '0;
         mar_q    <= '0;
         mdr_q    <= '0;
         inst_q   <= '0;
         opnd_q   <= '0;
         ovf_q    <= 1'b0;
         retire_q <= 1'b0;
      end else begin
         if (ctrl.ld_acc)  acc_q  <= a_bus;
         if (ctrl.ld_idx)  idx_q  <= a_bus;
         if (ctrl.ld_pc)   pc_q   <= a_bus;
         if (ctrl.ld_mar)  mar_q  <= a_bus;
         if (ctrl.ld_mdr)  mdr_q  <= mem_rdata;
         if (ctrl.ld_inst) inst_q <= mdr_q;
         if (ctrl.ld_opnd) opnd_q <= mdr_q;
         if (ctrl.ld_ovf)  ovf_q  <= add_ovf;
         retire_q <= ctrl.last;
      end
   end

   assign mem_rd_en = ctrl.rd_en;
   assign mem_addr  = mar_q;
   assign acc_o     = acc_q;
   assign idx_o     = idx_q;
   assign pc_o      = pc_q;
   assign ir_o      = inst_q;
   assign ovf_o     = ovf_q;
   assign retire_o  = retire_q;

endmodule

// File: rtl/acc_dp_chk.sv
module acc_dp_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_en,
   input logic [DATA_W-1:0] acc_o,
   input logic [DATA_W-1:0] idx_o,
   input logic [DATA_W-1:0] pc_o,
   input logic              ovf_o,
   input logic              retire_o
);

   // R9
   retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_o |=> !retire_o);

   // R3
   read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pc_o) |-> (pc_o == $past(pc_o) + DATA_W'(1)));

   // R5
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(idx_o) |-> retire_o);

   // R7
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ovf_o) |-> retire_o);

   // R4
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc_o) |-> retire_o);

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!retire_o && !mem_rd_en));

endmodule

bind acc_datapath_seq acc_dp_chk #(.DATA_W(DATA_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_rd_en(mem_rd_en),
   .acc_o    (acc_o),
   .idx_o    (idx_o),
   .pc_o     (pc_o),
   .ovf_o    (ovf_o),
   .retire_o (retire_o)
);

// File: tb/acc_datapath_seq_tb_top.sv
module acc_datapath_seq_tb_top;

   localparam int N_INSTR = 11;
   localparam int WD_LIMIT = 2000;

   typedef struct {
      logic [15:0] a;
      logic [15:0] x;
      logic [15:0] p;
      logic [15:0] ir;
      logic        ov;
      int          len;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic [15:0] acc_o, idx_o, pc_o, ir_o;
   logic        ovf_o, retire_o;

   logic [15:0] mem [256];
   exp_t        exp_q [$];
   logic [15:0] addr_q [$];

   int n_chk = 0;
   int n_bad = 0;
   int n_ret = 0;
   int cyc = 0;
   int last_cyc = 0;
   bit running = 1'b0;

   always #10 clk = ~clk;

   acc_datapath_seq dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mem_rd_en(mem_rd_en),
      .mem_addr (mem_addr),
      .mem_rdata(mem_rdata),
      .acc_o    (acc_o),
      .idx_o    (idx_o),
      .pc_o     (pc_o),
      .ir_o     (ir_o),
      .ovf_o    (ovf_o),
      .retire_o (retire_o)
   );

   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Driver: walks the program with a reference model, queuing expectations.
   task automatic drive_model();
      logic [15:0] a = '0, x = '0, p = '0, ir, d, s;
      logic        ov = 1'b0;
      exp_t        e;
      for (int k = 0; k < N_INSTR; k++) begin
         ir = mem[p[7:0]];
         addr_q.push_back(p);
         p = p + 16'd1;
         e.len = 5;
         if (ir[15:8] inside {8'h01, 8'h02, 8'h03}) begin
            addr_q.push_back({8'h00, ir[7:0]});
            d = mem[ir[7:0]];
            e.len = 9;
            case (ir[15:8])
               8'h01: a = d;
               8'h02: x = d;
               default: begin
                  s  = a + d;
                  ov = (a[15] == d[15]) && (s[15] != a[15]);
                  a  = s;
               end
            endcase
         end
         e.a = a; e.x = x; e.p = p; e.ir = ir; e.ov = ov;
         exp_q.push_back(e);
      end
   endtask

   // Monitor: compares read addresses and retired state against the queues.
   always @(negedge clk) begin
      if (running) begin
         cyc++;
         if (mem_rd_en) begin
            if (addr_q.size() == 0) begin
               check("R3", "unexpected read", 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
               // R2 R3 R8 R10: fetch at P, operand at zero-extended field
               check("R10", "read address", 32'(mem_addr), 32'(addr_q.pop_front()));
            end
         end
         if (retire_o) begin
            exp_t e;
            e = exp_q.pop_front();
            check("R4", "acc", 32'(acc_o), 32'(e.a));
            check("R5", "idx", 32'(idx_o), 32'(e.x));
            check("R2", "pc", 32'(pc_o), 32'(e.p));
            check("R9", "ir", 32'(ir_o), 32'(e.ir));
            check("R7", "ovf", 32'(ovf_o), 32'(e.ov));
            if (n_ret > 0) check("R3", "instr cycles", 32'(cyc - last_cyc), 32'(e.len));
            last_cyc = cyc;
            n_ret++;
            if (n_ret == N_INSTR) running = 1'b0;
         end
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      mem[0]  = 16'h0180;  // R4 load A 7FFF
      mem[1]  = 16'h0381;  // R6 R7 +1 -> 8000, overflow
      mem[2]  = 16'h0282;  // R5 load X, flag kept
      mem[3]  = 16'h0383;  // R7 8000+8000 -> 0000, overflow
      mem[4]  = 16'h0184;  // R4 load A FFFF
      mem[5]  = 16'h0385;  // R6 carry dropped, flag cleared
      mem[6]  = 16'hFF86;  // R8 unknown opcode, no operand read
      mem[7]  = 16'h0386;
      mem[8]  = 16'h0387;
      mem[9]  = 16'h02FF;  // R10 top of direct range
      mem[10] = 16'h0000;  // R8 zero opcode
      mem[8'h80] = 16'h7FFF;
      mem[8'h81] = 16'h0001;
      mem[8'h82] = 16'h1234;
      mem[8'h83] = 16'h8000;
      mem[8'h84] = 16'hFFFF;
      mem[8'h85] = 16'h0001;
      mem[8'h86] = 16'h1234;
      mem[8'h87] = 16'h8000;
      mem[8'hFF] = 16'hBEEF;
      drive_model();

      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1", "acc", 32'(acc_o), 32'h0);
      check("R1", "idx", 32'(idx_o), 32'h0);
      check("R1", "pc", 32'(pc_o), 32'h0);
      check("R1", "ovf", 32'(ovf_o), 32'h0);
      check("R1", "rd_en", 32'(mem_rd_en), 32'h0);
      check("R1", "retire", 32'(retire_o), 32'h0);
      rst_n   = 1'b1;
      running = 1'b1;

      for (int w = 0; w < WD_LIMIT && running; w++) @(negedge clk);
      if (running) begin
         n_chk++;
         n_bad++;
         $display("FAIL R9 watchdog: actual %0d retires expected %0d", n_ret, N_INSTR);
         running = 1'b0;
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule